// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel flash device. A client hands it one operation (a byte program or an erase), together with a target address and, for a program, the data byte. The poller then drives the command write pulses onto a request/acknowledge bus. Once enough pulses have gone out, it reads the device status byte at the target address until the operation has finished, has failed, or has run too long.

Two completion tests are available, chosen per operation by a mode input. The data-compare test looks at bit 7 of each status read. The toggle test compares whole consecutive reads. A failure bit that is seen while the operation is still running triggers a short confirmation before an error is declared. After any error or timeout, the poller writes a reset command to the device before it gives the result back to the client.

Top module: `flash_done_poller`

## Requirements
- R1: After an accepted start, the block issues exactly PROG_PULSES (default 4) write transactions for a program (`op_erase`=0) or ERASE_PULSES (default 6) for an erase (`op_erase`=1) before its first read. Write k (0-based) carries data k, except the final write of a program, which carries `op_data`.
- R2: Every transaction of an operation targets the address latched at start, including all status reads and the reset command.
- R3: In data-compare mode (`op_toggle`=0), a status read completes the operation with result OK (code 0) when its bit 7 equals the expected bit. The expected bit is `op_data[7]` for a program and 1 for an erase. Completion takes priority over bit 5 in the same read.
- R4: In toggle mode (`op_toggle`=1), the operation completes with OK when two consecutive status reads return identical bytes. The first read of an operation never completes it.
- R5: A status read that does not complete the operation but has bit 5 set starts a confirmation. This is one further read in data-compare mode, or two further reads compared with each other in toggle mode. If that confirmation shows completion, the result is OK; otherwise it is ERR (code 1).
- R6: On ERR or TIMEOUT, exactly one write of RESET_CMD (default 0xF0) is issued after the last read and before done. On OK, no write follows the reads.
- R7: The bus request, once raised, stays high with address, write flag and write data unchanged until the cycle in which acknowledge is sampled high, and is low in the following cycle.
- R8: A watchdog counts clock cycles spent polling since start. Before each new status read, if WDOG_LIMIT cycles have been reached, no read is issued and the result is TIMEOUT (code 2).
- R9: `done` is a single-cycle pulse with `result` valid in that cycle. `busy` is high from the cycle after start is accepted through the done cycle. A start pulse while busy is ignored.
- R10: Out of reset, `busy`, `done` and `bus_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new operation (accepted when idle) |
| op_erase | input | 1 | 1 = erase, 0 = byte program |
| op_toggle | input | 1 | 1 = toggle completion test, 0 = data-compare test |
| op_addr | input | AW | Target address |
| op_data | input | DW | Program data (expected final byte) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 OK, 1 ERR, 2 TIMEOUT |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Transaction acknowledge (one cycle) |
| bus_rdata | input | DW | Read data, valid with acknowledge |

## Verification
The bench uses the default 16-bit address, 8-bit data and 4/6 pulse counts, so the pulse count boundary of both command types is exercised. It lowers WDOG_LIMIT to 150 cycles, which lets a device that never finishes run into TIMEOUT within a few hundred cycles. At the same time, the limit stays well above the longest genuine busy window the device model produces. The device model can finish after a chosen number of busy reads, fail permanently, or raise bit 5 just before finishing. This reaches the confirmation path in both modes, and the bench randomises acknowledge latency.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_ERR     = 2'd1,
      RES_TIMEOUT = 2'd2
   } res_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_POLL,
      ST_RECHK,
      ST_RSTCMD,
      ST_FIN
   } st_e;
endpackage

// File: rtl/fpoll_judge.sv
// Interprets one status byte: completion and failure indication.
module fpoll_judge #(
   parameter int unsigned DW        = 8,
   parameter int unsigned DPOLL_BIT = 7,
   parameter int unsigned FAULT_BIT = 5
) (
   input  logic          toggle_mode,
   input  logic          exp_bit,
   input  logic [DW-1:0] rdata,
   input  logic [DW-1:0] prev,
   input  logic          prev_ok,
   output logic          complete,
   output logic          fault
);
   if (DPOLL_BIT >= DW) begin : g_bad_dpoll
      $error("fpoll_judge: DPOLL_BIT outside data width");
   end
   if (FAULT_BIT >= DW) begin : g_bad_fault
      $error("fpoll_judge: FAULT_BIT outside data width");
   end

   logic same_as_prev;
   logic dbit_match;

   assign same_as_prev = prev_ok && (rdata == prev);
   assign dbit_match   = (rdata[DPOLL_BIT] == exp_bit);
   assign complete     = toggle_mode ? same_as_prev : dbit_match;
   assign fault        = rdata[FAULT_BIT];
endmodule

// File: rtl/fpoll_pulse_ctr.sv
// Counts acknowledged command write pulses up to the command's need.
module fpoll_pulse_ctr #(
   parameter int unsigned PROG_PULSES  = 4,
   parameter int unsigned ERASE_PULSES = 6,
   parameter int unsigned CW           = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          is_erase,
   input  logic          step,
   output logic [CW-1:0] idx,
   output logic          last,
   output logic          full
);
   localparam int unsigned MAXP = (PROG_PULSES > ERASE_PULSES) ? PROG_PULSES : ERASE_PULSES;

   if (CW < $clog2(MAXP + 1)) begin : g_bad_cw
      $error("fpoll_pulse_ctr: CW too narrow");
   end
   if (PROG_PULSES < 1 || ERASE_PULSES < 1) begin : g_bad_cnt
      $error("fpoll_pulse_ctr: pulse counts must be at least one");
   end

   logic [CW-1:0] need;
   assign need = is_erase ? CW'(ERASE_PULSES) : CW'(PROG_PULSES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clear) begin
         idx <= '0;
      end else if (step && (idx != need)) begin
         idx <= idx + 1'b1;
      end
   end

   assign last = (idx == need - 1'b1);
   assign full = (idx == need);

   p_step_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !full)
      else $error("p_step_bounded_r1: command pulse beyond the required count");
endmodule

// File: rtl/fpoll_wdog.sv
// Polling-time watchdog; a zero limit removes it.
module fpoll_wdog #(
   parameter int unsigned LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);
   if (LIMIT == 0) begin : g_off
      assign expired = 1'b0;
   end else begin : g_on
      localparam int unsigned WW = $clog2(LIMIT + 1);
      logic [WW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (clear) begin
            cnt <= '0;
         end else if (run && (cnt != WW'(LIMIT))) begin
            cnt <= cnt + 1'b1;
         end
      end

      assign expired = (cnt == WW'(LIMIT));

      p_expiry_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (expired && !clear) |=> expired)
         else $error("p_expiry_sticky_r8: watchdog expiry lost");
   end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
   import fpoll_pkg::*;
#(
   parameter int unsigned AW           = 16,
   parameter int unsigned DW           = 8,
   parameter int unsigned PROG_PULSES  = 4,
   parameter int unsigned ERASE_PULSES = 6,
   parameter int unsigned WDOG_LIMIT   = 4096,
   parameter int unsigned DPOLL_BIT    = 7,
   parameter int unsigned FAULT_BIT    = 5,
   parameter logic [7:0]  RESET_CMD    = 8'hF0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          op_erase,
   input  logic          op_toggle,
   input  logic [AW-1:0] op_addr,
   input  logic [DW-1:0] op_data,
   output logic          busy,
   output logic          done,
   output logic [1:0]    result,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_ack,
   input  logic [DW-1:0] bus_rdata
);
   localparam int unsigned MAXP = (PROG_PULSES > ERASE_PULSES) ? PROG_PULSES : ERASE_PULSES;
   localparam int unsigned PCW  = $clog2(MAXP + 1);

   if (DW < 8) begin : g_bad_dw
      $error("flash_done_poller: DW must be at least 8");
   end
   if (AW < 1) begin : g_bad_aw
      $error("flash_done_poller: AW must be positive");
   end

   st_e           st_q;
   res_e          res_q;
   logic          req_q;
   logic          erase_q;
   logic          tog_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic [DW-1:0] prev_q;
   logic          prev_ok_q;
   logic          rchk_half_q;

   logic          accept;
   logic          xfer;
   logic          exp_bit;
   logic          prev_ok_eff;
   logic          complete;
   logic          fault;
   logic [PCW-1:0] pulse_idx;
   logic          pulse_last;
   logic          pulse_full;
   logic          wd_expired;
   logic          polling;

   assign accept  = (st_q == ST_IDLE) && start;
   assign xfer    = req_q && bus_ack;
   assign exp_bit = erase_q ? 1'b1 : data_q[DPOLL_BIT];
   assign polling = (st_q == ST_POLL) || (st_q == ST_RECHK);
   // first read of a toggle confirmation only seeds the comparison
   assign prev_ok_eff = prev_ok_q && !((st_q == ST_RECHK) && tog_q && !rchk_half_q);

   fpoll_judge #(
      .DW        (DW),
      .DPOLL_BIT (DPOLL_BIT),
      .FAULT_BIT (FAULT_BIT)
   ) u_judge (
      .toggle_mode (tog_q),
      .exp_bit     (exp_bit),
      .rdata       (bus_rdata),
      .prev        (prev_q),
      .prev_ok     (prev_ok_eff),
      .complete    (complete),
      .fault       (fault)
   );

   fpoll_pulse_ctr #(
      .PROG_PULSES  (PROG_PULSES),
      .ERASE_PULSES (ERASE_PULSES),
      .CW           (PCW)
   ) u_pulses (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .is_erase (erase_q),
      .step     (xfer && (st_q == ST_CMD)),
      .idx      (pulse_idx),
      .last     (pulse_last),
      .full     (pulse_full)
   );

   fpoll_wdog #(
      .LIMIT (WDOG_LIMIT)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .run     (polling),
      .expired (wd_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         res_q       <= RES_OK;
         req_q       <= 1'b0;
         erase_q     <= 1'b0;
         tog_q       <= 1'b0;
         addr_q      <= '0;
         data_q      <= '0;
         prev_q      <= '0;
         prev_ok_q   <= 1'b0;
         rchk_half_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q        <= ST_CMD;
                  res_q       <= RES_OK;
                  erase_q     <= op_erase;
                  tog_q       <= op_toggle;
                  addr_q      <= op_addr;
                  data_q      <= op_data;
                  prev_ok_q   <= 1'b0;
                  rchk_half_q <= 1'b0;
               end
            end
            ST_CMD: begin
               if (!req_q) begin
                  req_q <= 1'b1;
               end else if (bus_ack) begin
                  req_q <= 1'b0;
                  if (pulse_last) st_q <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (!req_q) begin
                  if (wd_expired) begin
                     res_q <= RES_TIMEOUT;
                     st_q  <= ST_RSTCMD;
                  end else begin
                     req_q <= 1'b1;
                  end
               end else if (bus_ack) begin
                  req_q     <= 1'b0;
                  prev_q    <= bus_rdata;
                  prev_ok_q <= 1'b1;
                  if (complete) begin
                     st_q <= ST_FIN;
                  end else if (fault) begin
                     st_q        <= ST_RECHK;
                     rchk_half_q <= 1'b0;
                  end
               end
            end
            ST_RECHK: begin
               if (!req_q) begin
                  req_q <= 1'b1;
               end else if (bus_ack) begin
                  req_q     <= 1'b0;
                  prev_q    <= bus_rdata;
                  prev_ok_q <= 1'b1;
                  if (tog_q && !rchk_half_q) begin
                     rchk_half_q <= 1'b1;
                  end else if (complete) begin
                     st_q <= ST_FIN;
                  end else begin
                     res_q <= RES_ERR;
                     st_q  <= ST_RSTCMD;
                  end
               end
            end
            ST_RSTCMD: begin
               if (!req_q) begin
                  req_q <= 1'b1;
               end else if (bus_ack) begin
                  req_q <= 1'b0;
                  st_q  <= ST_FIN;
               end
            end
            ST_FIN: begin
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_wdata = '0;
      if (st_q == ST_CMD) begin
         bus_wdata = (pulse_last && !erase_q) ? data_q : DW'(pulse_idx);
      end else if (st_q == ST_RSTCMD) begin
         bus_wdata = DW'(RESET_CMD);
      end
   end

   assign bus_req  = req_q;
   assign bus_we   = (st_q == ST_CMD) || (st_q == ST_RSTCMD);
   assign bus_addr = addr_q;
   assign busy     = (st_q != ST_IDLE);
   assign done     = (st_q == ST_FIN);
   assign result   = res_q;

   p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> bus_req)
      else $error("p_req_hold_r7: request withdrawn before acknowledge");

   p_fields_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)))
      else $error("p_fields_stable_r7: transaction fields changed while pending");

   p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack) |=> !bus_req)
      else $error("p_req_drop_r7: request not dropped after acknowledge");

   p_read_after_pulses_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |-> pulse_full)
      else $error("p_read_after_pulses_r1: status read before command pulses finished");

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("p_done_pulse_r9: done longer than one cycle");

   p_fail_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (result != 2'd0)) |-> ($past(st_q) == ST_RSTCMD))
      else $error("p_fail_reset_r6: failure reported without reset command");
endmodule

// File: tb/flash_done_poller_test.sv
`timescale 1ns/1ps
module flash_done_poller_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op_erase = 1'b0;
   logic        op_toggle = 1'b0;
   logic [15:0] op_addr = '0;
   logic [7:0]  op_data = '0;
   logic        busy, done;
   logic [1:0]  result;
   logic        bus_req, bus_we;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic        bus_ack = 1'b0;
   logic [7:0]  bus_rdata = '0;

   always #2.5 clk = ~clk;

   flash_done_poller #(.WDOG_LIMIT(150)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
      .op_toggle(op_toggle), .op_addr(op_addr), .op_data(op_data),
      .busy(busy), .done(done), .result(result),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // device model scenario: 0 finishes, 1 fails, 2 bit5 then finishes, 3 hangs
   int          sc_kind, sc_k;
   logic        sc_exp7;
   logic [7:0]  sc_final;
   logic [15:0] cur_addr;
   int wr_pre, rd_cnt, wr_post, rst_cmds, bad_addr, delay;
   logic [7:0]  last_pre;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] status_byte(input int i);
      logic [7:0] b;
      b = {~sc_exp7, i[0], 1'b0, 5'b10110};
      case (sc_kind)
         0: return (i < sc_k) ? b : sc_final;
         1: begin
            if (i >= sc_k) b[5] = 1'b1;
            return b;
         end
         2: begin
            if (i < sc_k - 1) return b;
            if (i == sc_k - 1) begin b[5] = 1'b1; return b; end
            return sc_final;
         end
         default: return b;
      endcase
   endfunction

   function automatic int exp_result(input int kind);
      case (kind)
         0, 2:    return 0;
         1:       return 1;
         default: return 2;
      endcase
   endfunction

   // bus responder
   initial begin
      delay = 0;
      forever begin
         @(negedge clk);
         if (bus_ack) begin
            bus_ack = 1'b0;
         end else if (bus_req) begin
            if (delay > 0) begin
               delay--;
            end else begin
               bus_ack = 1'b1;
               delay = $urandom_range(0, 2);
               if (bus_addr != cur_addr) bad_addr++;
               if (bus_we) begin
                  if (rd_cnt == 0) begin
                     wr_pre++;
                     last_pre = bus_wdata;
                  end else begin
                     wr_post++;
                     if (bus_wdata == 8'hF0) rst_cmds++;
                  end
               end else begin
                  bus_rdata = status_byte(rd_cnt);
                  rd_cnt++;
               end
            end
         end
      end
   end

   task automatic run_op(input bit erase, input bit tog, input int kind, input int k,
                         input logic [15:0] addr, input logic [7:0] data, input bit poke);
      int cyc;
      int exp_r;
      string rq;
      sc_kind  = kind;
      sc_k     = k;
      sc_exp7  = erase ? 1'b1 : data[7];
      sc_final = erase ? 8'hFF : data;
      cur_addr = addr;
      wr_pre = 0; rd_cnt = 0; wr_post = 0; rst_cmds = 0; bad_addr = 0;
      last_pre = '0;
      exp_r = exp_result(kind);
      @(negedge clk);
      start = 1'b1; op_erase = erase; op_toggle = tog; op_addr = addr; op_data = data;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R9", "busy after start", busy, 1);
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1; op_addr = ~addr; op_erase = ~erase;
         @(negedge clk);
         start = 1'b0;
      end
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      check(done == 1'b1, "R9", "done seen", done, 1);
      check(wr_pre == (erase ? 6 : 4), "R1", "pulses before first read", wr_pre, erase ? 6 : 4);
      if (!erase) check(last_pre == data, "R1", "final program pulse data", last_pre, data);
      check(bad_addr == 0, poke ? "R9" : "R2", "transactions off target address", bad_addr, 0);
      if (kind == 3)       rq = "R8";
      else if (kind != 0)  rq = "R5";
      else if (tog)        rq = "R4";
      else                 rq = "R3";
      check(result == 2'(exp_r), rq, "result code", result, exp_r);
      check(rst_cmds == (exp_r != 0 ? 1 : 0) && wr_post == rst_cmds, "R6",
            "writes after polling", wr_post, exp_r != 0 ? 1 : 0);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R9", "done pulse width / idle", {done, busy}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0 && bus_req == 1'b0, "R10", "reset outputs",
            {busy, done, bus_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && bus_req == 1'b0, "R10", "idle after reset", {busy, bus_req}, 0);
      void'($urandom(32'd20240611));
      // directed corners
      run_op(1'b0, 1'b0, 0, 1, 16'h1234, 8'h35, 1'b0);  // R3 program, bit7 low
      run_op(1'b0, 1'b0, 0, 3, 16'h0040, 8'hA5, 1'b0);  // R3 final byte with bit5 set
      run_op(1'b1, 1'b0, 0, 2, 16'hFFFF, 8'h00, 1'b0);  // R3 erase expects 1
      run_op(1'b1, 1'b1, 0, 4, 16'h8000, 8'h00, 1'b0);  // R4 erase toggle
      run_op(1'b0, 1'b1, 0, 1, 16'h0001, 8'h7E, 1'b0);  // R4 program toggle
      run_op(1'b0, 1'b0, 2, 1, 16'h2222, 8'hC3, 1'b0);  // R5 race, data mode
      run_op(1'b1, 1'b1, 2, 1, 16'h3333, 8'h00, 1'b0);  // R5 race at first read, toggle
      run_op(1'b0, 1'b0, 1, 2, 16'h4444, 8'h0F, 1'b0);  // R5 failure, data mode
      run_op(1'b0, 1'b1, 1, 3, 16'h5555, 8'hF0, 1'b0);  // R5 failure, toggle
      run_op(1'b1, 1'b0, 3, 0, 16'h6666, 8'h00, 1'b0);  // R8 timeout
      run_op(1'b0, 1'b1, 0, 2, 16'h7777, 8'h11, 1'b1);  // R9 start ignored while busy
      // random mix
      for (int n = 0; n < 24; n++) begin
         int kind;
         kind = $urandom_range(0, 9);
         kind = (kind < 4) ? 0 : (kind < 6) ? 2 : (kind < 8) ? 1 : 3;
         run_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), kind,
                $urandom_range(1, 5), 16'($urandom), 8'($urandom), 1'b0);
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule